// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block drives four independent pulse-width-modulated outputs from a single work clock. Each channel has three registers on a simple single-cycle register bus. The mode word holds an enable bit, a polarity bit and a 10-bit clock divider. The period word gives the length of one output cycle in prescaled ticks. The duty word gives how many of those ticks the output spends at its active level.

A running channel counts prescaled ticks from zero up to the period and then wraps. Its output is active while the tick count is below the duty value. Period and duty are copied into working copies only at a wrap, or continuously while the channel is disabled. A running channel therefore never emits a shortened or merged cycle. The divider and polarity take effect immediately. Software reconfigures a channel by clearing enable, rewriting the registers and setting enable again, and the channel then starts a fresh period.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads 0. Every output sits at logic 1, because a polarity bit of 0 selects the inverted sense and that sense is inactive high.
- R2: Channel c (0..3) has its mode word at byte address (c+1)*16, its period at (c+1)*16+4 and its duty at (c+1)*16+8. In the mode word, bit 0 is enable, bit 1 is polarity and bits 11:2 are the divider. Period and duty are 16 bits wide. Each register reads back the value last written, with unused upper bits read as zero.
- R3: Reads of any other address return 0, and writes to it change no register and no output. Those addresses are 0x00-0x0F, slot +12 of a bank, addresses above bank 4, and any address with bits 1:0 non-zero.
- R4: While a channel is disabled, its output equals the inverse of its polarity bit and its counters stay at zero.
- R5: With divider D (1..1023), period P (P≥1) and duty N (0<N<P) and polarity 1, the output is high for N*D cycles and low for (P-N)*D cycles of every P*D-cycle period.
- R6: A divider value of 0 behaves exactly like a divider of 1.
- R7: A duty of 0 keeps the output inactive for the whole period. A duty of at least the period keeps it active for the whole period.
- R8: With polarity 0 the output is the logical inverse of what polarity 1 would give.
- R9: Period and duty writes to a running channel take effect at the next period wrap. The current period completes with the old values.
- R10: In the cycle after enable is written to 1, a fresh period begins at tick 0, using the period and duty written while the channel was disabled.
- R11: The four channels run independently; traffic to one channel's registers never alters another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Work clock; bus and counters run on it |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the address |
| pwm_o | output | 4 | PWM outputs, bit c belongs to channel c |

## Verification
Wrong internal state shows up on the pins within a single prescaled tick. A prescaler that wraps early or late stretches or shortens the current output level. A tick counter that wraps at the wrong count moves the next edge. A working copy loaded at the wrong moment changes the high time in the middle of a period. The bench runs a per-cycle reference model of all four channels and compares every output pin on every clock. Any such fault is therefore reported in the first cycle where an edge appears or fails to appear. Register faults are caught the moment the register is read back.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  // register slot inside a channel bank, taken from address bits 3:2
  typedef enum logic [1:0] {
    SLOT_MODE   = 2'd0,
    SLOT_PERIOD = 2'd1,
    SLOT_DUTY   = 2'd2,
    SLOT_NONE   = 2'd3
  } reg_slot_e;

  // bit positions inside the mode word
  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_POL_BIT = 1;
  localparam int MODE_DIV_LSB = 2;

  // a bank spans 16 bytes; bank 0 is left empty
  localparam int BANK_SHIFT = 4;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_quad_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mode_i,
  input  logic              wr_period_i,
  input  logic              wr_duty_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  reg_slot_e         rslot_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              pol_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  duty_o
);

  localparam int MODE_W = DIV_W + MODE_DIV_LSB;

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CNT_W-1:0]  period_q, period_d;
  logic [CNT_W-1:0]  duty_q, duty_d;

  always_comb begin
    mode_d   = wdata_i[MODE_W-1:0];
    period_d = wdata_i[CNT_W-1:0];
    duty_d   = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      period_q <= '0;
      duty_q   <= '0;
    end else begin
      if (wr_mode_i)   mode_q   <= mode_d;
      if (wr_period_i) period_q <= period_d;
      if (wr_duty_i)   duty_q   <= duty_d;
    end
  end

  assign en_o     = mode_q[MODE_EN_BIT];
  assign pol_o    = mode_q[MODE_POL_BIT];
  assign div_o    = mode_q[MODE_W-1:MODE_DIV_LSB];
  assign period_o = period_q;
  assign duty_o   = duty_q;

  always_comb begin
    unique case (rslot_i)
      SLOT_MODE:   rdata_o = DATA_W'(mode_q);
      SLOT_PERIOD: rdata_o = DATA_W'(period_q);
      SLOT_DUTY:   rdata_o = DATA_W'(duty_q);
      default:     rdata_o = '0;
    endcase
  end

  AST_MODE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode_i |=> {div_o, pol_o, en_o} == $past(wdata_i[MODE_W-1:0])); // R2
  AST_PERIOD_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_period_i |=> period_o == $past(wdata_i[CNT_W-1:0])); // R2

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int DIV_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);

  logic [DIV_W-1:0] pre_q, pre_d, pre_last;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_sh_q, duty_sh_q;
  logic [CNT_W:0]   cnt_inc;
  logic             tick, wrap, load_sh, active;

  // prescaler and tick counter next state
  always_comb begin
    pre_last = (div_i == '0) ? '0 : div_i - 1'b1;
    tick     = (pre_q >= pre_last);
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    wrap     = tick && (cnt_inc >= {1'b0, per_sh_q});
    load_sh  = !en_i || wrap;
    pre_d    = pre_q;
    cnt_d    = cnt_q;
    if (!en_i) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      pre_d = '0;
      cnt_d = wrap ? '0 : cnt_inc[CNT_W-1:0];
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  // working copies of period and duty, loaded only at a wrap or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_sh_q  <= '0;
      duty_sh_q <= '0;
    end else if (load_sh) begin
      per_sh_q  <= period_i;
      duty_sh_q <= duty_i;
    end
  end

  assign active = en_i && (cnt_q < duty_sh_q);
  assign pwm_o  = active ? pol_i : ~pol_i;

  AST_IDLE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> (pre_q == '0) && (cnt_q == '0)); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(wrap)) |-> ($stable(per_sh_q) && $stable(duty_sh_q))); // R9
  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && per_sh_q != '0) |-> cnt_q < per_sh_q); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (cnt_q == '0) && (pre_q == '0)); // R10
  AST_ZERO_DUTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_sh_q == '0) |-> pwm_o == ~pol_i); // R7

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 10,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);

  localparam int BANK_W = ADDR_W - BANK_SHIFT;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  logic [BANK_W-1:0]        bank;
  reg_slot_e                slot;
  logic                     aligned;
  logic [NUM_CH-1:0]        hit;
  logic                     wr_acc;
  logic [DATA_W-1:0]        ch_rdata [NUM_CH];

  assign bank    = bus_addr_i[ADDR_W-1:BANK_SHIFT];
  assign slot    = reg_slot_e'(bus_addr_i[BANK_SHIFT-1:2]);
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign wr_acc  = bus_sel_i && bus_we_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             en, pol;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] period, duty;

    assign hit[c] = aligned && (slot != SLOT_NONE) && (bank == BANK_W'(c + 1));

    pwm_chan_regs #(
      .DIV_W (DIV_W),
      .CNT_W (CNT_W),
      .DATA_W(DATA_W)
    ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_int_n),
      .wr_mode_i  (wr_acc && hit[c] && (slot == SLOT_MODE)),
      .wr_period_i(wr_acc && hit[c] && (slot == SLOT_PERIOD)),
      .wr_duty_i  (wr_acc && hit[c] && (slot == SLOT_DUTY)),
      .wdata_i    (bus_wdata_i),
      .rslot_i    (slot),
      .rdata_o    (ch_rdata[c]),
      .en_o       (en),
      .pol_o      (pol),
      .div_o      (div),
      .period_o   (period),
      .duty_o     (duty)
    );

    pwm_chan_core #(
      .DIV_W(DIV_W),
      .CNT_W(CNT_W)
    ) u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_int_n),
      .en_i    (en),
      .pol_i   (pol),
      .div_i   (div),
      .period_i(period),
      .duty_i  (duty),
      .pwm_o   (pwm_o[c])
    );
  end

  // read mux: at most one bank is hit
  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit[c]) bus_rdata_o = ch_rdata[c];
    end
  end

  AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |-> bus_rdata_o == '0); // R3

endmodule

// File: tb/sim_pwm_quad.sv
`timescale 1ns/1ps
module sim_pwm_quad;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  pwm;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit cmp_on = 1'b0;

  // reference state
  int m_en[NCH], m_pol[NCH], m_div[NCH], m_per[NCH], m_duty[NCH];
  int m_psh[NCH], m_dsh[NCH], m_pre[NCH], m_cnt[NCH];

  always #2 clk = ~clk;

  pwm_quad u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  function automatic int slot_of(input logic [7:0] a, output int ch);
    ch = int'(a[7:4]) - 1;
    if (a[1:0] != 2'b00 || ch < 0 || ch >= NCH || a[3:2] == 2'd3) return -1;
    return int'(a[3:2]);
  endfunction

  function automatic int m_read(input logic [7:0] a);
    int ch, s;
    s = slot_of(a, ch);
    case (s)
      0: return m_en[ch] | (m_pol[ch] << 1) | (m_div[ch] << 2);
      1: return m_per[ch];
      2: return m_duty[ch];
      default: return 0;
    endcase
  endfunction

  function automatic int m_out(input int c);
    if (m_en[c] != 0 && m_cnt[c] < m_dsh[c]) return m_pol[c];
    return (m_pol[c] != 0) ? 0 : 1;
  endfunction

  // cycle-by-cycle reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_en[c] = 0; m_pol[c] = 0; m_div[c] = 0; m_per[c] = 0; m_duty[c] = 0;
        m_psh[c] = 0; m_dsh[c] = 0; m_pre[c] = 0; m_cnt[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (m_en[c] == 0) begin
          m_pre[c] = 0; m_cnt[c] = 0; m_psh[c] = m_per[c]; m_dsh[c] = m_duty[c];
        end else begin
          int d;
          d = (m_div[c] == 0) ? 1 : m_div[c];
          if (m_pre[c] >= d - 1) begin
            m_pre[c] = 0;
            if (m_cnt[c] + 1 >= m_psh[c]) begin
              m_cnt[c] = 0; m_psh[c] = m_per[c]; m_dsh[c] = m_duty[c];
            end else m_cnt[c] = m_cnt[c] + 1;
          end else m_pre[c] = m_pre[c] + 1;
        end
      end
      if (sel && we) begin
        int ch, s;
        s = slot_of(addr, ch);
        if (s == 0) begin
          m_en[ch] = int'(wdata[0]); m_pol[ch] = int'(wdata[1]);
          m_div[ch] = int'(wdata[11:2]);
        end else if (s == 1) m_per[ch] = int'(wdata[15:0]);
        else if (s == 2) m_duty[ch] = int'(wdata[15:0]);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output pin on every cycle
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int c = 0; c < NCH; c++) chk(phase, int'(pwm[c]), m_out(c));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    chk(req, int'(rdata), m_read(a));
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm[ch]) hi++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mode(input int div, input int pol, input int en);
    return 32'((div << 2) | (pol << 1) | en);
  endfunction

  function automatic logic [7:0] ba(input int ch, input int slot);
    return 8'((ch + 1) * 16 + slot * 4);
  endfunction

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int c = 0; c < NCH; c++) begin
      chk("R1", int'(pwm[c]), 1);
      rd_chk(ba(c, 0), "R1");
      rd_chk(ba(c, 1), "R1");
    end
    cmp_on = 1'b1;

    // R2/R5: channel 0, div 3, period 5, duty 2
    phase = "R5";
    wr(ba(0, 1), 32'd5);
    wr(ba(0, 2), 32'd2);
    wr(ba(0, 0), mode(3, 1, 1));
    count_high(0, 30, hi);
    chk("R5", hi, 12);
    rd_chk(ba(0, 0), "R2");
    rd_chk(ba(0, 1), "R2");
    rd_chk(ba(0, 2), "R2");
    wr(ba(1, 1), 32'hABCD_1234);
    rd_chk(ba(1, 1), "R2");

    // R6: divider 0 acts as 1 on channel 1
    phase = "R6";
    wr(ba(1, 1), 32'd4);
    wr(ba(1, 2), 32'd1);
    wr(ba(1, 0), mode(0, 1, 1));
    count_high(1, 8, hi);
    chk("R6", hi, 2);

    // R7: duty 0 on channel 2, duty above period on channel 3
    phase = "R7";
    wr(ba(2, 1), 32'd3);
    wr(ba(2, 2), 32'd0);
    wr(ba(2, 0), mode(2, 1, 1));
    count_high(2, 12, hi);
    chk("R7", hi, 0);
    wr(ba(3, 1), 32'd3);
    wr(ba(3, 2), 32'd9);
    wr(ba(3, 0), mode(1, 1, 1));
    count_high(3, 12, hi);
    chk("R7", hi, 12);

    // R8: inverted polarity on channel 1
    phase = "R8";
    wr(ba(1, 0), mode(0, 0, 0));
    wr(ba(1, 0), mode(0, 0, 1));
    count_high(1, 8, hi);
    chk("R8", hi, 6);

    // R9: duty and period changes mid-period on channel 0
    phase = "R9";
    repeat (7) @(negedge clk);
    wr(ba(0, 2), 32'd4);
    repeat (5) @(negedge clk);
    wr(ba(0, 1), 32'd6);
    repeat (60) @(negedge clk);
    rd_chk(ba(0, 2), "R9");

    // R4/R10: disable, rewrite, re-enable channel 0
    phase = "R10";
    wr(ba(0, 0), mode(3, 1, 0));
    chk("R4", int'(pwm[0]), 0);
    repeat (3) @(negedge clk);
    chk("R4", int'(pwm[0]), 0);
    wr(ba(0, 1), 32'd2);
    wr(ba(0, 2), 32'd1);
    wr(ba(0, 0), mode(1, 1, 1));
    chk("R10", int'(pwm[0]), 1);
    count_high(0, 4, hi);
    chk("R10", hi, 2);

    // R3: unmapped writes and reads
    phase = "R3";
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h11, 32'h0000_0000);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'hF4, 32'hFFFF_FFFF);
    for (int c = 0; c < NCH; c++) begin
      rd_chk(ba(c, 0), "R3");
      rd_chk(ba(c, 1), "R3");
      rd_chk(ba(c, 2), "R3");
    end
    rd_chk(8'h00, "R3");
    rd_chk(8'h1C, "R3");
    rd_chk(8'h52, "R3");
    chk("R3", int'(rdata == 32'd0), 1);

    // R11: heavy traffic on channel 3 while others run
    phase = "R11";
    for (int k = 0; k < 6; k++) begin
      wr(ba(3, 2), 32'(k));
      wr(ba(3, 1), 32'(k + 2));
      repeat (5) @(negedge clk);
    end
    wr(ba(2, 0), mode(1023, 0, 1));
    repeat (100) @(negedge clk);

    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule